// File: doc/BRIEF.md
# Seven-slot LVDS pixel serializer

The block turns one parallel RGB pixel per pixel period into seven serial time slots on up to four data lanes, plus a clock lane that repeats a fixed slot pattern. It runs entirely on the 7x bit clock. An internal slot counter marks the pixel boundary, and the block raises `pix_take` during the last slot of each pixel. The colour, sync and data-enable inputs, together with the two mode inputs, are captured at the rising edge that ends that slot. The captured pixel then appears on the lanes over the next seven bit clocks, with slot 0 first. Inputs that change at any other time have no effect on the pixel being sent.

Two mode inputs choose the layout. `mode_wide` selects 24-bit colour on four lanes or 18-bit colour on three lanes. `mode_jeida` selects the alternative 24-bit ordering, which places the most significant colour bits on lanes 0 to 2 and the two least significant bits of each colour on lane 3. In 18-bit mode, the colour bits sit in bits [5:0] of each colour input. The current slot number is also an output, so a downstream word packer or a PHY model can align to it.

Top module: `lvds_pix_ser`

## Requirements
- R1: While reset is asserted, `slot_idx` is 6, `pix_take` is 1, all four `lane_d` bits are 0 and `lane_clk` is 1.
- R2: Out of reset, `slot_idx` counts 0,1,...,6 and wraps, one step per bit clock, and `pix_take` is 1 exactly when `slot_idx` is 6. The inputs present at the rising edge that ends slot 6 form the pixel shown in the following slots 0 to 6.
- R3: In the standard ordering (`mode_jeida`=0, or any 18-bit pixel), slots 0..6 carry, on lane 0: g0,r5,r4,r3,r2,r1,r0; on lane 1: b1,b0,g5,g4,g3,g2,g1; on lane 2, slots 3..6: b5,b4,b3,b2. Here rN is bit N of `px_red`, gN is bit N of `px_grn` and bN is bit N of `px_blu`.
- R4: In every mode, lane 2 slots 0, 1 and 2 carry `px_de`, `px_vs` and `px_hs` in that order.
- R5: In 24-bit standard mode (`mode_wide`=1, `mode_jeida`=0), lane 3 carries 0,b7,b6,g7,g6,r7,r6 over slots 0..6. Lane 3 slot 0 is 0 in every mode.
- R6: In 24-bit alternative mode (`mode_wide`=1, `mode_jeida`=1), slots 0..6 carry, on lane 0: g2,r7,r6,r5,r4,r3,r2; on lane 1: b3,b2,g7,g6,g5,g4,g3; on lane 2, slots 3..6: b7,b6,b5,b4; on lane 3: 0,b1,b0,g1,g0,r1,r0.
- R7: In 18-bit mode (`mode_wide`=0), lane 3 is 0 in all slots, and `mode_jeida` and bits [7:6] of each colour input have no effect on any lane.
- R8: `lane_clk` carries 1,1,0,0,0,1,1 over slots 0..6 on every pixel.
- R9: Changes to the pixel or mode inputs at any edge other than the one that ends slot 6 do not alter the pixel currently being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| px_red | input | 8 | Red component (bits [5:0] in 18-bit mode) |
| px_grn | input | 8 | Green component |
| px_blu | input | 8 | Blue component |
| px_de | input | 1 | Data enable |
| px_vs | input | 1 | Vertical sync |
| px_hs | input | 1 | Horizontal sync |
| mode_wide | input | 1 | 1: 24-bit on four lanes, 0: 18-bit on three lanes |
| mode_jeida | input | 1 | 1: alternative 24-bit ordering |
| pix_take | output | 1 | High in slot 6; inputs are captured at the following edge |
| slot_idx | output | 3 | Slot currently on the lanes, 0 to 6 |
| lane_d | output | 4 | Data lane bits for the current slot, bit n is lane n |
| lane_clk | output | 1 | Clock lane bit for the current slot |

## Verification
A single one-hot bit is walked through every colour position in each of the three layouts. Each such pixel shows that bit in exactly one lane and slot, so a swapped slot, a swapped lane or a wrong rotation between the two 24-bit orderings shows up as a miscompare at a known place. The three control bits are walked one at a time in both widths. This separates data enable from the two syncs and shows that the control slots do not move with the colour ordering. 18-bit pixels are sent with the upper colour bits set and the alternative ordering requested, which shows that both are ignored. Pixels whose inputs and modes are inverted partway through the pixel show that only the value present at the boundary edge is sent. Mixed pseudo-random pixels that switch modes from one pixel to the next cover the remaining combinations.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int unsigned SLOTS = 7;
  localparam int unsigned LANES = 4;
  localparam int unsigned CW    = 8;
  localparam int unsigned SW    = $clog2(SLOTS);
  localparam int unsigned ROT   = CW - 6;

  localparam logic [SW-1:0]    LAST_SLOT = SW'(SLOTS - 1);
  localparam logic [SLOTS-1:0] CLK_PAT   = 7'b1100011;

  typedef logic [LANES-1:0][SLOTS-1:0] lane_words_t;

  typedef struct packed {
    logic [CW-1:0] r;
    logic [CW-1:0] g;
    logic [CW-1:0] b;
    logic          de;
    logic          vs;
    logic          hs;
  } pixel_t;
endpackage

// File: rtl/lvds_slot_seq.sv
module lvds_slot_seq
  import lvds_ser_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot_o,
  output logic          take_o
);
  logic [SW-1:0] slot_q;
  logic [SW-1:0] slot_d;

  always_comb begin
    if (slot_q == LAST_SLOT) slot_d = '0;
    else                     slot_d = slot_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= LAST_SLOT;
    else        slot_q <= slot_d;
  end

  assign slot_o = slot_q;
  assign take_o = (slot_q == LAST_SLOT);

  // R2: the pixel boundary is followed by slot 0
  p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (slot_o == '0));

  // R2: inside a pixel the slot advances by one
  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |=> (slot_o == $past(slot_o) + SW'(1)));

  // R2: the slot never leaves 0..6
  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_o <= LAST_SLOT);
endmodule

// File: rtl/lvds_bit_map.sv
module lvds_bit_map
  import lvds_ser_pkg::*;
(
  input  pixel_t      px_i,
  input  logic        wide_i,
  input  logic        jeida_i,
  output lane_words_t words_o
);
  pixel_t c;

  // The alternative ordering equals the standard one applied to each
  // colour rotated right by two bits.
  always_comb begin
    c = px_i;
    if (wide_i && jeida_i) begin
      c.r = {px_i.r[ROT-1:0], px_i.r[CW-1:ROT]};
      c.g = {px_i.g[ROT-1:0], px_i.g[CW-1:ROT]};
      c.b = {px_i.b[ROT-1:0], px_i.b[CW-1:ROT]};
    end
  end

  // Bit n of each word is slot n.
  always_comb begin
    words_o[0] = {c.r[0], c.r[1], c.r[2], c.r[3], c.r[4], c.r[5], c.g[0]};
    words_o[1] = {c.g[1], c.g[2], c.g[3], c.g[4], c.g[5], c.b[0], c.b[1]};
    words_o[2] = {c.b[2], c.b[3], c.b[4], c.b[5], px_i.hs, px_i.vs, px_i.de};
    if (wide_i)
      words_o[3] = {c.r[6], c.r[7], c.g[6], c.g[7], c.b[6], c.b[7], 1'b0};
    else
      words_o[3] = '0;
  end
endmodule

// File: rtl/lvds_lane_out.sv
module lvds_lane_out
  import lvds_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  lane_words_t      words_i,
  input  logic [SW-1:0]    slot_i,
  output logic [LANES-1:0] lane_d_o,
  output logic             lane_clk_o
);
  lane_words_t words_q;
  lane_words_t words_d;

  always_comb begin
    if (load_i) words_d = words_i;
    else        words_d = words_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) words_q <= '0;
    else        words_q <= words_d;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_d_o[l] = words_q[l][slot_i];
  end

  assign lane_clk_o = CLK_PAT[slot_i];

  // R5: lane 3 slot 0 is reserved low
  p_rsvd_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i == '0) |-> !lane_d_o[LANES-1]);

  // R8: clock lane low in the middle three slots
  p_clk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i >= SW'(2) && slot_i <= SW'(4)) |-> !lane_clk_o);

  // R8: clock lane high in the outer slots
  p_clk_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i < SW'(2) || slot_i > SW'(4)) |-> lane_clk_o);
endmodule

// File: rtl/lvds_pix_ser.sv
module lvds_pix_ser
  import lvds_ser_pkg::*;
(
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic [CW-1:0]    px_red,
  input  logic [CW-1:0]    px_grn,
  input  logic [CW-1:0]    px_blu,
  input  logic             px_de,
  input  logic             px_vs,
  input  logic             px_hs,
  input  logic             mode_wide,
  input  logic             mode_jeida,
  output logic             pix_take,
  output logic [SW-1:0]    slot_idx,
  output logic [LANES-1:0] lane_d,
  output logic             lane_clk
);
  logic [1:0]  rst_pipe;
  logic        rst_q;
  pixel_t      px;
  lane_words_t words;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  assign px = '{r: px_red, g: px_grn, b: px_blu, de: px_de, vs: px_vs, hs: px_hs};

  lvds_slot_seq u_seq (
    .clk    (clk_bit),
    .rst_n  (rst_q),
    .slot_o (slot_idx),
    .take_o (pix_take)
  );

  lvds_bit_map u_map (
    .px_i    (px),
    .wide_i  (mode_wide),
    .jeida_i (mode_jeida),
    .words_o (words)
  );

  lvds_lane_out u_out (
    .clk        (clk_bit),
    .rst_n      (rst_q),
    .load_i     (pix_take),
    .words_i    (words),
    .slot_i     (slot_idx),
    .lane_d_o   (lane_d),
    .lane_clk_o (lane_clk)
  );

  // R4: data enable captured at the boundary appears in lane 2 slot 0
  p_de_slot_r4: assert property (@(posedge clk_bit) disable iff (!rst_q)
    (slot_idx == '0) |-> (lane_d[2] == $past(px_de)));

  // R7: an 18-bit pixel keeps lane 3 low in slot 1
  p_lane3_idle_r7: assert property (@(posedge clk_bit) disable iff (!rst_q)
    (slot_idx == SW'(1) && !$past(mode_wide, 2)) |-> !lane_d[3]);
endmodule

// File: tb/lvds_pix_ser_tb.sv
module lvds_pix_ser_tb;
  logic       clk_bit = 1'b0;
  logic       rst_n;
  logic [7:0] px_red, px_grn, px_blu;
  logic       px_de, px_vs, px_hs;
  logic       mode_wide, mode_jeida;
  logic       pix_take;
  logic [2:0] slot_idx;
  logic [3:0] lane_d;
  logic       lane_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0][6:0] w;
    string           tag;
  } exp_t;

  exp_t q[$];

  // Source codes: 0 zero, 1x red bit x, 2x green, 3x blue, 40 de, 41 vs, 42 hs
  int tab_std [4][7] = '{'{20,15,14,13,12,11,10},
                         '{31,30,25,24,23,22,21},
                         '{40,41,42,35,34,33,32},
                         '{ 0,37,36,27,26,17,16}};
  int tab_alt [4][7] = '{'{22,17,16,15,14,13,12},
                         '{33,32,27,26,25,24,23},
                         '{40,41,42,37,36,35,34},
                         '{ 0,31,30,21,20,11,10}};

  always #4 clk_bit = ~clk_bit;

  lvds_pix_ser u_dut (
    .clk_bit(clk_bit), .rst_n(rst_n),
    .px_red(px_red), .px_grn(px_grn), .px_blu(px_blu),
    .px_de(px_de), .px_vs(px_vs), .px_hs(px_hs),
    .mode_wide(mode_wide), .mode_jeida(mode_jeida),
    .pix_take(pix_take), .slot_idx(slot_idx),
    .lane_d(lane_d), .lane_clk(lane_clk)
  );

  function automatic logic pick(int code, logic [7:0] r, logic [7:0] g,
                                logic [7:0] b, logic [2:0] ctl);
    case (code / 10)
      1: return r[code % 10];
      2: return g[code % 10];
      3: return b[code % 10];
      4: return ctl[code % 10];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0][6:0] expect_words(logic [7:0] r, logic [7:0] g,
      logic [7:0] b, logic [2:0] ctl, logic w, logic j);
    logic [3:0][6:0] e;
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 7; s++) begin
        if (w && j)       e[l][s] = pick(tab_alt[l][s], r, g, b, ctl);
        else if (w || l < 3) e[l][s] = pick(tab_std[l][s], r, g, b, ctl);
        else              e[l][s] = 1'b0;
      end
    return e;
  endfunction

  // ctl: bit0 de, bit1 vs, bit2 hs
  task automatic send(logic [7:0] r, logic [7:0] g, logic [7:0] b,
                      logic [2:0] ctl, logic w, logic j, string tag, bit disturb);
    exp_t it;
    do @(negedge clk_bit); while (!pix_take);
    px_red = r; px_grn = g; px_blu = b;
    px_de = ctl[0]; px_vs = ctl[1]; px_hs = ctl[2];
    mode_wide = w; mode_jeida = j;
    it.w   = expect_words(r, g, b, ctl, w, j);
    it.tag = tag;
    q.push_back(it);
    if (disturb) begin
      repeat (3) @(negedge clk_bit);
      px_red = ~r; px_grn = ~g; px_blu = ~b;
      px_de = ~ctl[0]; px_vs = ~ctl[1]; px_hs = ~ctl[2];
      mode_wide = ~w; mode_jeida = ~j;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_bit);
      if (rst_n && slot_idx == 3'd0 && q.size() > 0) begin
        exp_t it;
        logic [3:0][6:0] got;
        logic [6:0] ck;
        bit seq_ok;
        it = q.pop_front();
        seq_ok = 1'b1;
        for (int s = 0; s < 7; s++) begin
          if (s > 0) @(negedge clk_bit);
          if (slot_idx != 3'(s) || pix_take != (s == 6)) seq_ok = 1'b0;
          for (int l = 0; l < 4; l++) got[l][s] = lane_d[l];
          ck[s] = lane_clk;
        end
        checks++;
        if (!seq_ok) begin
          fails++;
          $display("FAIL R2 slot sequence broken, got last slot %0d exp 6", slot_idx);
        end
        checks++;
        if (got !== it.w) begin
          fails++;
          $display("FAIL %s lanes got %h exp %h", it.tag, got, it.w);
        end
        checks++;
        if (ck !== 7'b1100011) begin
          fails++;
          $display("FAIL R8 clock lane got %b exp 1100011", ck);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired, got hung run exp completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0;
    px_red = '0; px_grn = '0; px_blu = '0;
    px_de = 0; px_vs = 0; px_hs = 0;
    mode_wide = 0; mode_jeida = 0;
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_bit);
      checks++;
      if (slot_idx !== 3'd6 || pix_take !== 1'b1 || lane_d !== 4'b0 || lane_clk !== 1'b1) begin
        fails++;
        $display("FAIL R1 reset got slot %0d take %b lanes %b clk %b exp 6 1 0000 1",
                 slot_idx, pix_take, lane_d, lane_clk);
      end
    end
    rst_n = 1'b1;
    repeat (10) @(negedge clk_bit);

    // R3: walking bit, 18-bit standard
    for (int i = 0; i < 18; i++) begin
      logic [17:0] v;
      v = 18'(1) << i;
      send({2'b00, v[5:0]}, {2'b00, v[11:6]}, {2'b00, v[17:12]}, 3'b000, 1'b0, 1'b0, "R3", 1'b0);
    end
    // R4: control bits, both widths and both orderings
    for (int i = 0; i < 3; i++) begin
      send(8'h00, 8'h00, 8'h00, 3'(1 << i), 1'b0, 1'b0, "R4", 1'b0);
      send(8'h00, 8'h00, 8'h00, 3'(1 << i), 1'b1, 1'b1, "R4", 1'b0);
    end
    // R5: walking bit, 24-bit standard
    for (int i = 0; i < 24; i++) begin
      logic [23:0] v;
      v = 24'(1) << i;
      send(v[7:0], v[15:8], v[23:16], 3'b000, 1'b1, 1'b0, "R5", 1'b0);
    end
    // R6: walking bit, 24-bit alternative ordering
    for (int i = 0; i < 24; i++) begin
      logic [23:0] v;
      v = 24'(1) << i;
      send(v[7:0], v[15:8], v[23:16], 3'b000, 1'b1, 1'b1, "R6", 1'b0);
    end
    // R7: 18-bit with upper bits set and alternative ordering requested
    send(8'hC0, 8'hC0, 8'hC0, 3'b000, 1'b0, 1'b1, "R7", 1'b0);
    send(8'hFF, 8'h00, 8'hFF, 3'b101, 1'b0, 1'b1, "R7", 1'b0);
    send(8'hC5, 8'hEA, 8'hD3, 3'b010, 1'b0, 1'b1, "R7", 1'b0);
    // R9: inputs and modes inverted in the middle of the pixel
    send(8'h5A, 8'h3C, 8'hA5, 3'b011, 1'b1, 1'b0, "R9", 1'b1);
    send(8'h81, 8'h7E, 8'h18, 3'b100, 1'b0, 1'b0, "R9", 1'b1);
    send(8'h0F, 8'hF0, 8'h33, 3'b001, 1'b1, 1'b1, "R9", 1'b1);
    send(8'h12, 8'h34, 8'h56, 3'b110, 1'b1, 1'b0, "R9", 1'b0);
    // Mixed pseudo-random pixels, modes changing per pixel
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr[7:0], lfsr[15:8], lfsr[23:16], lfsr[26:24], lfsr[27], lfsr[28],
           lfsr[27] ? (lfsr[28] ? "R6" : "R5") : "R3", 1'b0);
    end
    while (q.size() > 0) @(negedge clk_bit);
    repeat (10) @(negedge clk_bit);
    finish_run();
  end
endmodule